// File: doc/BRIEF.md
# Serial RAM Loader

This block is a hardware boot loader that sits between a byte-wide UART and the write port of a working RAM. It keeps a CPU in reset while a host, typically a person at a serial terminal, fills the RAM one byte at a time. While it waits for the host, it sends a ready character on the transmit side at a fixed interval. Once the host sends the start character, every following byte goes to the next RAM address, beginning at the RAM base. Two command characters are recognised while loading. One dumps the stored bytes back over the UART. The other releases the CPU to execute from the RAM base.

The UART side is a pair of valid-qualified byte streams. Receive bytes arrive as one-cycle `rx_valid` pulses, and a transmit byte is offered with `tx_valid` until the UART accepts it with `tx_ready`. The RAM is expected to have an asynchronous read port, so `ram_rdata` follows `ram_addr` in the same cycle. The dump uses that port to read bytes back. The beacon interval is `CLK_HZ / BEACON_HZ` clock cycles. The region size and the base address are parameters.

Top module: `serial_ram_loader`

## Requirements
- R1: While `rst_n` is low, `cpu_rst` is 1 and `tx_valid` and `ram_we` are 0. The loader then starts in the waiting state.
- R2: In the waiting state, a ready byte 0x40 ('@') is offered on `tx_data` once every `CLK_HZ/BEACON_HZ` cycles. It stays offered, unchanged, until `tx_ready` accepts it.
- R3: In the waiting state, the start byte 0x2A ('*') moves the loader to loading and drops any beacon that has not yet been sent. Any other received byte in the waiting state has no effect.
- R4: While loading, the n-th data byte received (counting from 0) is written to address `RAM_BASE + n`, with `ram_we` high for exactly the one cycle after the byte arrives.
- R5: Once `RAM_BYTES` bytes are stored, further data bytes are dropped and cause no RAM write.
- R6: While loading, the dump byte 0x2F ('/') with at least one byte stored sends every stored byte in address order, read back through `ram_addr`/`ram_rdata`. Each accepted byte advances to the next, and after the last one the loader returns to loading.
- R7: A dump byte received with nothing stored transmits nothing, and the loader stays in loading.
- R8: Received bytes that arrive during a dump are ignored: nothing is written and the byte count does not change.
- R9: While loading, the run byte 0x21 ('!') drops `cpu_rst` to 0 permanently. After that, received bytes are ignored and nothing is transmitted. Bytes 0x2F and 0x21 are never written to RAM.
- R10: `cpu_start_addr` always equals `RAM_BASE` (0xC000 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle pulse: a received byte is on `rx_data` |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | UART accepts the offered byte this cycle |
| tx_valid | output | 1 | A byte is offered on `tx_data` |
| tx_data | output | 8 | Byte to transmit |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM address for writes and dump reads |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | Asynchronous RAM read data at `ram_addr` |
| cpu_rst | output | 1 | CPU reset, active high |
| cpu_start_addr | output | ADDR_W | Address the CPU starts from after release |

## Verification
The start byte can arrive in the same cycle that a pending ready beacon is accepted by the UART. The bench holds `tx_ready` high, waits for the cycle in which `tx_valid` rises with the beacon, and drives 0x2A in that cycle. A reference model in the bench predicts outputs cycle by cycle and judges the result. It expects that beacon to be consumed, no further '@' afterwards, and the next data byte to land at the RAM base. A second overlap is a received byte that arrives while dump bytes are being accepted under alternating `tx_ready`. There the model expects the dump stream to be unchanged and no write to occur.

// File: rtl/sram_loader_pkg.sv
package sram_loader_pkg;

   typedef enum logic [1:0] {
      LD_WAIT = 2'd0,
      LD_FILL = 2'd1,
      LD_DUMP = 2'd2,
      LD_RUN  = 2'd3
   } ld_state_e;

   localparam logic [7:0] CH_READY = 8'h40;
   localparam logic [7:0] CH_START = 8'h2A;
   localparam logic [7:0] CH_DUMP  = 8'h2F;
   localparam logic [7:0] CH_RUN   = 8'h21;

endpackage

// File: rtl/loader_beacon.sv
module loader_beacon #(
   parameter int unsigned PERIOD = 125_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);

   if (PERIOD == 0) begin : g_bad_period
      $error("loader_beacon: PERIOD must be at least 1");
   end

   if (PERIOD <= 1) begin : g_every
      assign tick = en;
   end else begin : g_count
      localparam int unsigned CW = $clog2(PERIOD);
      localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt <= '0;
         else if (!en)        cnt <= '0;
         else if (cnt == LAST) cnt <= '0;
         else                 cnt <= cnt + 1'b1;
      end

      assign tick = en && (cnt == LAST);

      assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= LAST);
   end

endmodule

// File: rtl/loader_ptrs.sv
module loader_ptrs #(
   parameter int unsigned DEPTH = 8192,
   parameter int unsigned PW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          rd_clear,
   input  logic          rd_step,
   output logic [PW-1:0] wcount,
   output logic [PW-1:0] rcount,
   output logic          full,
   output logic          rd_last
);

   if (DEPTH == 0) begin : g_bad_depth
      $error("loader_ptrs: DEPTH must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    wcount <= '0;
      else if (push) wcount <= wcount + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rcount <= '0;
      else if (rd_clear) rcount <= '0;
      else if (rd_step)  rcount <= rcount + 1'b1;
   end

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_full_msb
      assign full = wcount[PW-1];
   end else begin : g_full_cmp
      assign full = (wcount == PW'(DEPTH));
   end

   assign rd_last = ((rcount + PW'(1)) == wcount);

   assert_push_not_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   assert_wcount_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> wcount >= $past(wcount));
   assert_rd_within_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_step |-> rcount < wcount);

endmodule

// File: rtl/serial_ram_loader.sv
module serial_ram_loader
   import sram_loader_pkg::*;
#(
   parameter int unsigned CLK_HZ    = 125_000_000,
   parameter int unsigned BEACON_HZ = 1,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned RAM_BASE  = 32'h0000_C000,
   parameter int unsigned RAM_BYTES = 8192
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              tx_ready,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [7:0]        ram_wdata,
   input  logic [7:0]        ram_rdata,
   output logic              cpu_rst,
   output logic [ADDR_W-1:0] cpu_start_addr
);

   localparam int unsigned BEACON_CYCLES = CLK_HZ / BEACON_HZ;
   localparam int unsigned PTR_W = $clog2(RAM_BYTES + 1);
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(RAM_BASE);

   if (BEACON_HZ == 0 || BEACON_CYCLES == 0) begin : g_bad_rate
      $error("serial_ram_loader: CLK_HZ/BEACON_HZ must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_aw
      $error("serial_ram_loader: ADDR_W must be 1..32");
   end
   if ((64'(RAM_BASE) + 64'(RAM_BYTES)) > (64'd1 << ADDR_W)) begin : g_bad_region
      $error("serial_ram_loader: RAM region exceeds address space");
   end

   ld_state_e state, state_nx;

   logic             beacon_tick, beacon_pend;
   logic             start_hit, wr_fire, dump_go;
   logic [PTR_W-1:0] wcount, rcount;
   logic             full, rd_last, rd_step;
   logic             we_q;
   logic [ADDR_W-1:0] wa_q;
   logic [7:0]       wd_q;

   loader_beacon #(.PERIOD(BEACON_CYCLES)) u_beacon (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (state == LD_WAIT),
      .tick (beacon_tick)
   );

   loader_ptrs #(.DEPTH(RAM_BYTES), .PW(PTR_W)) u_ptrs (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (wr_fire),
      .rd_clear(dump_go),
      .rd_step (rd_step),
      .wcount  (wcount),
      .rcount  (rcount),
      .full    (full),
      .rd_last (rd_last)
   );

   assign start_hit = (state == LD_WAIT) && rx_valid && (rx_data == CH_START);
   assign wr_fire   = (state == LD_FILL) && rx_valid && (rx_data != CH_DUMP)
                      && (rx_data != CH_RUN) && !full;
   assign dump_go   = (state == LD_FILL) && rx_valid && (rx_data == CH_DUMP)
                      && (wcount != '0);
   assign rd_step   = (state == LD_DUMP) && tx_ready;

   always_comb begin
      state_nx = state;
      unique case (state)
         LD_WAIT: if (start_hit) state_nx = LD_FILL;
         LD_FILL: begin
            if (rx_valid && rx_data == CH_RUN) state_nx = LD_RUN;
            else if (dump_go)                  state_nx = LD_DUMP;
         end
         LD_DUMP: if (tx_ready && rd_last) state_nx = LD_FILL;
         LD_RUN:  state_nx = LD_RUN;
         default: state_nx = LD_WAIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= LD_WAIT;
      else        state <= state_nx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) beacon_pend <= 1'b0;
      else        beacon_pend <= (state == LD_WAIT) && !start_hit
                                 && (beacon_tick || (beacon_pend && !tx_ready));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q <= 1'b0;
         wa_q <= BASE;
         wd_q <= '0;
      end else begin
         we_q <= wr_fire;
         if (wr_fire) begin
            wa_q <= BASE + ADDR_W'(wcount);
            wd_q <= rx_data;
         end
      end
   end

   assign tx_valid       = ((state == LD_WAIT) && beacon_pend) || (state == LD_DUMP);
   assign tx_data        = (state == LD_DUMP) ? ram_rdata : CH_READY;
   assign ram_we         = we_q;
   assign ram_wdata      = wd_q;
   assign ram_addr       = (state == LD_DUMP) ? (BASE + ADDR_W'(rcount)) : wa_q;
   assign cpu_rst        = (state != LD_RUN);
   assign cpu_start_addr = BASE;

   assert_beacon_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LD_WAIT && tx_valid && !tx_ready && !start_hit)
      |=> tx_valid && tx_data == CH_READY);
   assert_run_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rst |=> !cpu_rst);
   assert_run_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rst |-> !tx_valid && !ram_we);
   assert_dump_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      state == LD_DUMP |-> !ram_we);
   assert_we_in_region_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (64'(ram_addr) >= 64'(RAM_BASE))
                 && (64'(ram_addr) < 64'(RAM_BASE) + 64'(RAM_BYTES)));
   assert_cmd_not_stored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> ram_wdata != CH_DUMP && ram_wdata != CH_RUN);
   assert_wait_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      state == LD_WAIT |-> !ram_we);

endmodule

// File: tb/tb_serial_ram_loader.sv
module tb_serial_ram_loader;

   localparam int unsigned NB    = 40;
   localparam int unsigned DEPTH = 6;
   localparam logic [15:0] BASE  = 16'hC000;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n, rx_valid, tx_ready;
   logic [7:0]  rx_data;
   logic        tx_valid, ram_we, cpu_rst;
   logic [7:0]  tx_data, ram_wdata, ram_rdata;
   logic [15:0] ram_addr, cpu_start_addr;

   serial_ram_loader #(
      .CLK_HZ(NB), .BEACON_HZ(1), .ADDR_W(16), .RAM_BASE(32'h0000_C000), .RAM_BYTES(DEPTH)
   ) dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata), .cpu_rst(cpu_rst), .cpu_start_addr(cpu_start_addr)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   bit checking = 0;
   int wr_count = 0;

   logic [7:0] mem [0:DEPTH-1];
   logic [7:0] got[$];

   wire in_rng = (ram_addr >= BASE) && (ram_addr < BASE + 16'(DEPTH));
   assign ram_rdata = in_rng ? mem[ram_addr - BASE] : 8'h00;

   always @(posedge clk) begin
      if (rst_n && ram_we && in_rng) begin
         mem[ram_addr - BASE] <= ram_wdata;
         wr_count++;
      end
      if (rst_n && tx_valid && tx_ready) got.push_back(tx_data);
   end

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   // reference model: 0 wait, 1 fill, 2 dump, 3 run
   int         ms, mcnt, rp;
   bit         mpend, mwe, nwe, mtick;
   logic [15:0] maddr;
   logic [7:0]  mwd;
   logic [7:0]  wq[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         ms = 0; mcnt = 0; mpend = 0; rp = 0; mwe = 0; wq.delete();
      end else begin
         nwe = 0;
         case (ms)
            0: begin
               mtick = (mcnt == NB - 1);
               if (rx_valid && rx_data == 8'h2A) begin
                  ms = 1; mcnt = 0; mpend = 0;
               end else begin
                  mpend = mtick ? 1'b1 : (mpend && !tx_ready);
                  mcnt  = mtick ? 0 : mcnt + 1;
               end
            end
            1: if (rx_valid) begin
               if (rx_data == 8'h2F) begin
                  if (wq.size() > 0) begin ms = 2; rp = 0; end
               end else if (rx_data == 8'h21) begin
                  ms = 3;
               end else if (wq.size() < DEPTH) begin
                  nwe = 1; maddr = BASE + 16'(wq.size()); mwd = rx_data;
                  wq.push_back(rx_data);
               end
            end
            2: if (tx_ready) begin
               if (rp == wq.size() - 1) ms = 1;
               else rp++;
            end
            default: ;
         endcase
         mwe = nwe;
      end
   end

   always @(negedge clk) begin
      if (rst_n && checking) begin
         automatic string tg = (ms == 0) ? "R2" : (ms == 2) ? "R6" : (ms == 3) ? "R9" : "R4";
         automatic bit etv = (ms == 0 && mpend) || (ms == 2);
         chk(tg, "tx_valid", tx_valid, etv);
         if (etv) chk(tg, "tx_data", tx_data, (ms == 2) ? wq[rp] : 8'h40);
         chk("R4", "ram_we", ram_we, mwe);
         if (mwe) begin
            chk("R4", "ram_addr", ram_addr, maddr);
            chk("R4", "ram_wdata", ram_wdata, mwd);
         end
         chk("R9", "cpu_rst", cpu_rst, ms != 3);
         chk("R10", "cpu_start_addr", cpu_start_addr, BASE);
      end
   end

   task automatic send(input logic [7:0] b);
      rx_valid = 1'b1;
      rx_data  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; rx_valid = 1'b0; rx_data = 8'h00; tx_ready = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "reset cpu_rst", cpu_rst, 1);
      chk("R1", "reset tx_valid", tx_valid, 0);
      chk("R1", "reset ram_we", ram_we, 0);
      chk("R10", "reset start addr", cpu_start_addr, BASE);
      rst_n = 1'b1;
      checking = 1'b1;

      // R2: beacon appears and is held while the UART is busy
      repeat (NB + 5) @(negedge clk);
      chk("R2", "beacon held", tx_valid, 1);
      chk("R2", "beacon byte", tx_data, 8'h40);

      // R3: other bytes in the waiting state do nothing
      send(8'h41);
      send(8'h2F);
      @(negedge clk);
      chk("R3", "ignored writes", wr_count, 0);
      chk("R3", "still beaconing", tx_valid, 1);

      tx_ready = 1'b1;
      repeat (2 * NB) @(negedge clk);
      // start byte in the same cycle the beacon is accepted
      while (tx_valid !== 1'b1) @(negedge clk);
      send(8'h2A);
      chk("R3", "no beacon after start", tx_valid, 0);
      repeat (NB + 3) @(negedge clk);
      chk("R3", "quiet while loading", tx_valid, 0);

      // R7: empty dump
      got.delete();
      send(8'h2F);
      repeat (4) @(negedge clk);
      chk("R7", "empty dump sends nothing", got.size(), 0);

      // R4: three data bytes
      send(8'h11); send(8'hA5); send(8'h00);
      @(negedge clk);
      chk("R4", "write count", wr_count, 3);
      chk("R4", "mem[0]", mem[0], 8'h11);
      chk("R4", "mem[2]", mem[2], 8'h00);

      // R6 + R8: dump under alternating ready, byte injected mid-dump
      got.delete();
      tx_ready = 1'b0;
      send(8'h2F);
      for (int i = 0; i < 20; i++) begin
         tx_ready = i[0];
         rx_valid = (i == 3);
         rx_data  = 8'h77;
         @(negedge clk);
      end
      rx_valid = 1'b0;
      tx_ready = 1'b1;
      chk("R6", "dump length", got.size(), 3);
      if (got.size() == 3) begin
         chk("R6", "dump byte0", got[0], 8'h11);
         chk("R6", "dump byte1", got[1], 8'hA5);
         chk("R6", "dump byte2", got[2], 8'h00);
      end
      chk("R8", "no write during dump", wr_count, 3);

      // R5: overfill
      send(8'h31); send(8'h32); send(8'h33); send(8'h34); send(8'h35);
      @(negedge clk);
      chk("R5", "writes capped", wr_count, DEPTH);

      got.delete();
      send(8'h2F);
      repeat (10) @(negedge clk);
      chk("R6", "full dump length", got.size(), DEPTH);
      if (got.size() == DEPTH) begin
         chk("R6", "full dump byte3", got[3], 8'h31);
         chk("R5", "last stored byte", got[5], 8'h33);
      end

      // R9: run
      send(8'h21);
      chk("R9", "cpu released", cpu_rst, 0);
      chk("R10", "start addr at run", cpu_start_addr, BASE);
      got.delete();
      send(8'h2F); send(8'h99);
      repeat (5) @(negedge clk);
      chk("R9", "nothing sent after run", got.size(), 0);
      chk("R9", "nothing written after run", wr_count, DEPTH);
      chk("R9", "cpu stays released", cpu_rst, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not complete act=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule